// File: doc/BRIEF.md
# Serial-In Shift Register with Transparent Parallel Holding Stage

This block turns a serial bit stream into a parallel word. A chain of shift stages advances by one position on every rising clock edge, taking a new bit from the serial input. Behind each shift stage sits a storage bit that is transparent while the strobe is high and holds its value while the strobe is low. The storage word is presented on a parallel data vector. A single enable tells the surrounding logic whether that vector is driven onto its bus or left in high impedance.

Two cascade outputs carry the last shift stage to the next device in a daisy chain. One updates on the rising edge. The other is retimed onto the falling edge, which gives a receiver that has slow clock transitions half a period of margin. Typical uses are serial-to-parallel conversion and a holding register that keeps a remotely loaded control word steady while new bits shift in behind it.

The asynchronous active-low reset is an addition made for deterministic simulation. It clears every shift stage, every storage bit and both cascade outputs.

Top module: `shift_store_reg`

## Requirements
- R1: On every rising clock edge, `ser_in` enters stage 0 and every stage n takes the previous value of stage n-1. `par_data[0]` maps to stage 0, the stage nearest the serial input, and `par_data[STAGES-1]` maps to the last stage.
- R2: While `strobe` is 1, `par_data` equals the shift stages. This holds between clock edges too: raising `strobe` without a clock edge exposes the current stages immediately.
- R3: While `strobe` is 0, `par_data` keeps its value however many shifts take place.
- R4: `par_oe` equals `out_en`. A 0 means the parallel outputs are high impedance. `par_data` still carries the storage contents in that state.
- R5: Shifting and both cascade outputs behave the same whatever the values of `strobe` and `out_en`.
- R6: `ser_out_rise` equals the last shift stage. It changes only at a rising clock edge.
- R7: `ser_out_fall` takes the value of the last stage at each falling clock edge. It does not change at a rising edge.
- R8: `rst_n` = 0 clears all shift stages, all storage bits, `ser_out_rise` and `ser_out_fall` at once, without waiting for a clock edge.
- R9: Two instances, with the second one's `ser_in` fed from the first one's `ser_out_rise` and both sharing clock and strobe, behave as one shift register of 2*STAGES stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock. The rising edge shifts; the falling edge retimes `ser_out_fall` |
| rst_n | input | 1 | Asynchronous active-low clear |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | 1 = storage transparent, 0 = storage holds |
| out_en | input | 1 | Parallel output enable |
| par_data | output | STAGES | Storage contents; bit 0 maps to stage 0 |
| par_oe | output | 1 | 1 = drive `par_data`, 0 = high impedance |
| ser_out_rise | output | 1 | Last stage, updated on the rising edge |
| ser_out_fall | output | 1 | Last stage, retimed to the falling edge |

## Verification
The assertions check four things on every rising edge. The chain must advance by exactly one position from the sampled input. The storage must match the stages while the strobe is high and stay frozen while it is low. The falling-edge output must carry the last stage that was set at the previous rising edge. The bench scenarios cover what a clocked property cannot see. These are transparency that opens between clock edges, the asynchronous reset, the isolation of the parallel enable from everything else, and the 16-stage behaviour of two chained instances driven with random bits.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned SSR_STAGES = 8;
    typedef logic [SSR_STAGES-1:0] ssr_word_t;
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [STAGES-1:0] stage_q
);
    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stages;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d.stages[0] = bit_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d.stages[i] = chain_q.stages[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign stage_q = chain_q.stages;

    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q == {$past(stage_q[TOP-1:0]), $past(bit_in)});
endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic [STAGES-1:0] word_in,
    output logic [STAGES-1:0] word_q
);
    logic [STAGES-1:0] hold_q;

    always_latch begin
        if (!rst_n)    hold_q <= '0;
        else if (open) hold_q <= word_in;
    end

    assign word_q = hold_q;

    // R2
    store_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> word_q == word_in);

    // R3
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && $past(!open)) |-> $stable(word_q));
endmodule

// File: rtl/ssr_fall_retime.sv
module ssr_fall_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic last_bit,
    output logic late_q
);
    logic late_d, late_r;

    always_comb late_d = last_bit;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) late_r <= 1'b0;
        else        late_r <= late_d;
    end

    assign late_q = late_r;

    // R7
    fall_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_q == last_bit);
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_data,
    output logic              par_oe,
    output logic              ser_out_rise,
    output logic              ser_out_fall
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stage_word;
    logic [STAGES-1:0] store_word;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk(clk), .rst_n(rst_n), .bit_in(ser_in), .stage_q(stage_word)
    );

    ssr_store_latch #(.STAGES(STAGES)) u_store (
        .clk(clk), .rst_n(rst_n), .open(strobe),
        .word_in(stage_word), .word_q(store_word)
    );

    ssr_fall_retime u_late (
        .clk(clk), .rst_n(rst_n), .last_bit(stage_word[LAST]), .late_q(ser_out_fall)
    );

    assign par_data     = store_word;
    assign par_oe       = out_en;
    assign ser_out_rise = stage_word[LAST];

    // R6
    rise_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_rise == $past(stage_word[LAST-1]));
endmodule

// File: tb/shift_store_reg_test.sv
module shift_store_reg_test;
    localparam int unsigned N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, strobe = 1'b0, out_en = 1'b0;
    logic [N-1:0] par_data, par_data2;
    logic par_oe, par_oe2, rise_o, fall_o, rise2, fall2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2*N-1:0] m_chain;
    logic [N-1:0]   m_store, m_store2;
    logic           m_fall;

    always #4 clk = ~clk;

    shift_store_reg #(.STAGES(N)) uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
        .par_data(par_data), .par_oe(par_oe), .ser_out_rise(rise_o), .ser_out_fall(fall_o)
    );

    shift_store_reg #(.STAGES(N)) uut2 (
        .clk(clk), .rst_n(rst_n), .ser_in(rise_o), .strobe(strobe), .out_en(out_en),
        .par_data(par_data2), .par_oe(par_oe2), .ser_out_rise(rise2), .ser_out_fall(fall2)
    );

    function automatic logic [2*N-1:0] shifted(logic [2*N-1:0] c, logic b);
        return {c[2*N-2:0], b};
    endfunction

    task automatic chk(bit ok, string tag, logic [2*N-1:0] act, logic [2*N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called during the low clock phase; drives inputs, then runs one rising edge.
    task automatic cyc(logic b, logic s, logic e);
        logic prev_fall;
        ser_in = b;
        out_en = e;
        if (s && !strobe) begin
            strobe = 1'b1;
            m_store  = m_chain[N-1:0];
            m_store2 = m_chain[2*N-1:N];
            #1;
            chk(par_data == m_store, "R2 open between edges", par_data, m_store);
        end else begin
            strobe = s;
        end
        @(posedge clk);
        prev_fall = m_fall;
        m_chain = shifted(m_chain, b);
        if (strobe) begin
            m_store  = m_chain[N-1:0];
            m_store2 = m_chain[2*N-1:N];
        end
        #2;
        chk(rise_o == m_chain[N-1], "R6 rise output", rise_o, m_chain[N-1]);
        chk(fall_o == prev_fall, "R7 no change at rising edge", fall_o, prev_fall);
        #4;
        m_fall = m_chain[N-1];
        chk(fall_o == m_fall, "R7 falling edge copy", fall_o, m_fall);
        chk(par_data == m_store, "R1 R2 R3 storage word", par_data, m_store);
        chk(par_oe == e, "R4 enable", par_oe, e);
        chk(rise2 == m_chain[2*N-1], "R9 cascade tail", rise2, m_chain[2*N-1]);
        chk(par_data2 == m_store2, "R9 cascade word", par_data2, m_store2);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] frozen;
        void'($urandom(32'd2024));
        m_chain = '0; m_store = '0; m_store2 = '0; m_fall = 1'b0;
        #10;
        // R8 reset state
        chk(par_data == '0 && rise_o == 1'b0 && fall_o == 1'b0, "R8 reset state", par_data, 0);
        @(posedge clk); #2 rst_n = 1'b1;
        #4;
        // R1 walking one with strobe open: bit 0 is stage 0
        cyc(1'b1, 1'b1, 1'b1);
        chk(par_data == 8'h01, "R1 stage0 mapping", par_data, 8'h01);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1);
        chk(par_data == 8'h08, "R1 walking one", par_data, 8'h08);
        // R3 hold while shifting ones in
        cyc(1'b1, 1'b0, 1'b1);
        frozen = par_data;
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b1);
        chk(par_data == frozen, "R3 hold over shifts", par_data, frozen);
        // R4 R5 enable off: storage and serial path unaffected
        for (int i = 0; i < 4; i++) cyc(1'(i), 1'b0, 1'b0);
        chk(par_oe == 1'b0 && par_data == frozen, "R4 highz keeps storage", par_data, frozen);
        cyc(1'b1, 1'b1, 1'b0);
        chk(rise_o == m_chain[N-1], "R5 shifting under enable off", rise_o, m_chain[N-1]);
        // R2 R5 random mix, cascade R9
        for (int i = 0; i < 300; i++)
            cyc(1'($urandom), ($urandom % 4) != 0, 1'($urandom));
        // R9 fill all 16 stages with a known pattern
        for (int i = 0; i < 2*N; i++) cyc(1'((16'hA5C3 >> (2*N-1-i)) & 1), 1'b1, 1'b1);
        chk({par_data2, par_data} == 16'hA5C3, "R9 sixteen-stage word", {par_data2, par_data}, 16'hA5C3);
        // R8 asynchronous clear mid-cycle
        #1 rst_n = 1'b0;
        #1;
        chk(par_data == '0 && rise_o == 1'b0 && fall_o == 1'b0 && par_data2 == '0,
            "R8 async clear", {par_data2, par_data}, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule